// File: doc/BRIEF.md
# T1 Yellow Alarm Detector

This block decides whether the far end of a T1 line is signalling a yellow alarm, also called a remote alarm indication. It does not frame the line. An upstream framer pulls out the bits it needs and hands them over as strobed values. In bit-2 mode these are the second bit of every channel. In F-bit mode they are the twelfth framing bit of each superframe. In ESF mode they are the bytes received on the extended-superframe data link.

Two inputs pick the detection rule. When the ESF select is high, the data-link pattern rule applies. When it is low, a second select chooses between the two superframe rules. The block drives a level output that holds the alarm state. It also drives two single-cycle pulses that mark when the alarm turns on and when it turns off. Changing the rule in use starts detection over from nothing.

Top module: `t1_rai_detector`

## Requirements
- R1: After reset, `yel_alarm`, `yel_set` and `yel_clr` are all 0, and the mode in use is bit-2 mode.
- R2: In bit-2 mode (`esf_sel`=0, `fbit_sel`=0), the channel strobes are counted in consecutive 256-strobe blocks. A block starts at reset or at a mode change. If at least 254 strobes in a block carry `ch_bit2`=0, the alarm is on after the clock edge that samples the block's last strobe.
- R3: In bit-2 mode, a block in which fewer than 254 strobes carry a zero turns the alarm off at the edge that samples the block's last strobe.
- R4: In F-bit mode (`esf_sel`=0, `fbit_sel`=1), two consecutive F-bit strobes with `fb_val`=1 turn the alarm on at the edge that samples the second strobe. Strobes whose values alternate change nothing.
- R5: In F-bit mode, two consecutive F-bit strobes with `fb_val`=0 turn the alarm off. A single zero between ones leaves the alarm on.
- R6: In ESF mode (`esf_sel`=1), the data-link bytes are paired: the first byte of a pair comes first in time. A pair counts as a pattern match when it is 0x00 followed by 0xFF. Pairs are grouped in consecutive blocks of 16, and a block in which all 16 pairs match turns the alarm on at the edge that samples the block's last byte.
- R7: In ESF mode, a block with 14 or fewer matching pairs turns the alarm off. A block with exactly 15 matches leaves the alarm as it was.
- R8: Strobes that belong to a source the current mode does not use have no effect. Changing `fbit_sel` while `esf_sel`=1 is not a mode change. Cycles with no strobe leave the alarm unchanged.
- R9: A change of the selected mode clears the alarm at the next edge, along with every partial block, pair and F-bit history. Any strobe in that cycle is dropped.
- R10: `yel_set` is high for exactly the one cycle in which `yel_alarm` has just gone from 0 to 1. `yel_clr` is high for exactly the one cycle in which it has just gone from 1 to 0. This includes a clear caused by a mode change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| esf_sel | input | 1 | 1 selects the ESF data-link rule |
| fbit_sel | input | 1 | With `esf_sel`=0: 0 selects the channel bit-2 rule, 1 selects the F-bit rule |
| ch_stb | input | 1 | Marks a valid channel bit 2 |
| ch_bit2 | input | 1 | Bit 2 of the current channel |
| fb_stb | input | 1 | Marks a valid twelfth framing bit |
| fb_val | input | 1 | Value of the twelfth framing bit |
| dl_stb | input | 1 | Marks a valid data-link byte |
| dl_byte | input | 8 | Received data-link byte |
| yel_alarm | output | 1 | Yellow alarm level |
| yel_set | output | 1 | One-cycle pulse when the alarm turns on |
| yel_clr | output | 1 | One-cycle pulse when the alarm turns off |

## Verification
The hardest case to reach is showing that a mode change really empties a partly filled block. A stale channel count produces no visible effect until a later block ends, and it then ends early. To expose this, the stimulus sends 100 zero-bit channels and switches to F-bit mode and straight back. It then sends 156 more zero-bit channels, a number that would complete a stale block. The alarm must stay off until a full fresh block of 256 channels has been sent. The 254 and 253 channel-block boundaries and the 15-of-16 data-link hold case are driven as well.

// File: rtl/t1_rai_pkg.sv
package t1_rai_pkg;

    typedef enum logic [1:0] {
        MODE_BIT2 = 2'd0,
        MODE_FBIT = 2'd1,
        MODE_FDL  = 2'd2
    } rai_mode_e;

    function automatic rai_mode_e decode_mode(input logic esf, input logic fsel);
        if (esf)
            return MODE_FDL;
        else if (fsel)
            return MODE_FBIT;
        else
            return MODE_BIT2;
    endfunction

endpackage

// File: rtl/rai_chan_eval.sv
module rai_chan_eval #(
    parameter int BLOCK   = 256,
    parameter int SET_MIN = 254
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic stb,
    input  logic bit2,
    output logic set_req,
    output logic clr_req
);
    localparam int CW = $clog2(BLOCK + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] zeros;
    } chan_st_t;

    chan_st_t s_d, s_q;
    logic [CW-1:0] zsum;

    always_comb begin
        s_d     = s_q;
        set_req = 1'b0;
        clr_req = 1'b0;
        zsum    = s_q.zeros + CW'(!bit2);
        if (flush) begin
            s_d = '0;
        end else if (stb) begin
            if (s_q.cnt == CW'(BLOCK - 1)) begin
                set_req = (zsum >= CW'(SET_MIN));
                clr_req = !(zsum >= CW'(SET_MIN));
                s_d     = '0;
            end else begin
                s_d.cnt   = s_q.cnt + 1'b1;
                s_d.zeros = zsum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R2: the block counters stay inside one block
    p_chan_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt < CW'(BLOCK)) && (s_q.zeros <= s_q.cnt));

    // R3: a verdict is only reached on a sampled strobe
    p_chan_verdict_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req || clr_req) |-> (stb && !flush));

endmodule

// File: rtl/rai_fbit_eval.sv
module rai_fbit_eval (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic stb,
    input  logic val,
    output logic set_req,
    output logic clr_req
);
    typedef struct packed {
        logic have;
        logic last;
    } fbit_st_t;

    fbit_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        set_req = 1'b0;
        clr_req = 1'b0;
        if (flush) begin
            s_d = '0;
        end else if (stb) begin
            if (s_q.have && (s_q.last == val)) begin
                set_req = val;
                clr_req = !val;
            end
            s_d.have = 1'b1;
            s_d.last = val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R4: a set decision follows a sampled one from the previous strobe
    p_fbit_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> (s_q.have && s_q.last));

    // R5: never both decisions at once
    p_fbit_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_req && clr_req));

endmodule

// File: rtl/rai_fdl_eval.sv
module rai_fdl_eval #(
    parameter int         PATTERNS = 16,
    parameter int         CLR_MAX  = 14,
    parameter logic [7:0] HI_BYTE  = 8'h00,
    parameter logic [7:0] LO_BYTE  = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush,
    input  logic       stb,
    input  logic [7:0] byte_in,
    output logic       set_req,
    output logic       clr_req
);
    localparam int PW = $clog2(PATTERNS + 1);

    typedef struct packed {
        logic          half;
        logic          first_ok;
        logic [PW-1:0] pcnt;
        logic [PW-1:0] hits;
    } fdl_st_t;

    fdl_st_t s_d, s_q;
    logic [PW-1:0] hsum;

    always_comb begin
        s_d     = s_q;
        set_req = 1'b0;
        clr_req = 1'b0;
        hsum    = s_q.hits + PW'(s_q.first_ok && (byte_in == LO_BYTE));
        if (flush) begin
            s_d = '0;
        end else if (stb) begin
            if (!s_q.half) begin
                s_d.half     = 1'b1;
                s_d.first_ok = (byte_in == HI_BYTE);
            end else if (s_q.pcnt == PW'(PATTERNS - 1)) begin
                set_req = (hsum == PW'(PATTERNS));
                clr_req = (hsum <= PW'(CLR_MAX));
                s_d     = '0;
            end else begin
                s_d.half     = 1'b0;
                s_d.first_ok = 1'b0;
                s_d.pcnt     = s_q.pcnt + 1'b1;
                s_d.hits     = hsum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // R6: pattern counters stay inside one block
    p_fdl_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.pcnt < PW'(PATTERNS)) && (s_q.hits <= s_q.pcnt));

    // R7: a verdict only comes on the second byte of a pair
    p_fdl_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_req || clr_req) |-> (stb && s_q.half));

endmodule

// File: rtl/t1_rai_detector.sv
module t1_rai_detector
    import t1_rai_pkg::*;
#(
    parameter int CH_BLOCK    = 256,
    parameter int CH_SET_MIN  = 254,
    parameter int PAT_BLOCK   = 16,
    parameter int PAT_CLR_MAX = 14
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       esf_sel,
    input  logic       fbit_sel,
    input  logic       ch_stb,
    input  logic       ch_bit2,
    input  logic       fb_stb,
    input  logic       fb_val,
    input  logic       dl_stb,
    input  logic [7:0] dl_byte,
    output logic       yel_alarm,
    output logic       yel_set,
    output logic       yel_clr
);
    typedef struct packed {
        rai_mode_e mode;
        logic      alarm;
        logic      set_p;
        logic      clr_p;
    } top_st_t;

    top_st_t   s_d, s_q;
    rai_mode_e cur_mode;
    logic      mode_chg;
    logic      ch_set, ch_clr, fb_set, fb_clr, dl_set, dl_clr;
    logic      sel_set, sel_clr;

    assign cur_mode = decode_mode(esf_sel, fbit_sel);
    assign mode_chg = (cur_mode != s_q.mode);

    rai_chan_eval #(.BLOCK(CH_BLOCK), .SET_MIN(CH_SET_MIN)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .flush(mode_chg || (cur_mode != MODE_BIT2)),
        .stb(ch_stb), .bit2(ch_bit2),
        .set_req(ch_set), .clr_req(ch_clr)
    );

    rai_fbit_eval u_fbit (
        .clk(clk), .rst_n(rst_n),
        .flush(mode_chg || (cur_mode != MODE_FBIT)),
        .stb(fb_stb), .val(fb_val),
        .set_req(fb_set), .clr_req(fb_clr)
    );

    rai_fdl_eval #(.PATTERNS(PAT_BLOCK), .CLR_MAX(PAT_CLR_MAX)) u_fdl (
        .clk(clk), .rst_n(rst_n),
        .flush(mode_chg || (cur_mode != MODE_FDL)),
        .stb(dl_stb), .byte_in(dl_byte),
        .set_req(dl_set), .clr_req(dl_clr)
    );

    always_comb begin
        unique case (cur_mode)
            MODE_FBIT: begin sel_set = fb_set; sel_clr = fb_clr; end
            MODE_FDL:  begin sel_set = dl_set; sel_clr = dl_clr; end
            default:   begin sel_set = ch_set; sel_clr = ch_clr; end
        endcase
    end

    always_comb begin
        s_d       = s_q;
        s_d.mode  = cur_mode;
        s_d.set_p = 1'b0;
        s_d.clr_p = 1'b0;
        if (mode_chg) begin
            s_d.alarm = 1'b0;
            s_d.clr_p = s_q.alarm;
        end else if (sel_set && !s_q.alarm) begin
            s_d.alarm = 1'b1;
            s_d.set_p = 1'b1;
        end else if (sel_clr && s_q.alarm) begin
            s_d.alarm = 1'b0;
            s_d.clr_p = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{mode: MODE_BIT2, alarm: 1'b0, set_p: 1'b0, clr_p: 1'b0};
        else        s_q <= s_d;
    end

    assign yel_alarm = s_q.alarm;
    assign yel_set   = s_q.set_p;
    assign yel_clr   = s_q.clr_p;

    // R9: a mode change leaves the alarm off
    p_mode_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (decode_mode(esf_sel, fbit_sel) != s_q.mode) |=> !yel_alarm);

    // R8: a cycle with no strobe and a steady mode holds the alarm
    p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ch_stb && !fb_stb && !dl_stb && (decode_mode(esf_sel, fbit_sel) == s_q.mode))
        |=> $stable(yel_alarm));

    // R10: pulses are exclusive and agree with the level
    p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(yel_set && yel_clr));
    p_set_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        yel_set |-> yel_alarm);
    p_clr_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
        yel_clr |-> !yel_alarm);

endmodule

// File: tb/t1_rai_detector_test.sv
module t1_rai_detector_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       esf_sel = 1'b0, fbit_sel = 1'b0;
    logic       ch_stb = 1'b0, ch_bit2 = 1'b1;
    logic       fb_stb = 1'b0, fb_val = 1'b0;
    logic       dl_stb = 1'b0;
    logic [7:0] dl_byte = 8'h00;
    logic       yel_alarm, yel_set, yel_clr;

    int    n_cmp = 0, n_bad = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    t1_rai_detector uut (
        .clk(clk), .rst_n(rst_n), .esf_sel(esf_sel), .fbit_sel(fbit_sel),
        .ch_stb(ch_stb), .ch_bit2(ch_bit2), .fb_stb(fb_stb), .fb_val(fb_val),
        .dl_stb(dl_stb), .dl_byte(dl_byte),
        .yel_alarm(yel_alarm), .yel_set(yel_set), .yel_clr(yel_clr)
    );

    // behavioural reference model
    int m_alarm = 0, m_set = 0, m_clr = 0;
    int m_mode = 0;
    int ch_n = 0, ch_z = 0;
    int f_prev = -1;
    logic [7:0] dlq[$];

    function automatic int mode_of(logic e, logic f);
        return e ? 2 : (f ? 1 : 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_alarm = 0; m_set = 0; m_clr = 0; m_mode = 0;
            ch_n = 0; ch_z = 0; f_prev = -1; dlq.delete();
        end else begin
            int want_on, want_off, md;
            want_on = 0; want_off = 0; m_set = 0; m_clr = 0;
            md = mode_of(esf_sel, fbit_sel);
            if (md != m_mode) begin
                ch_n = 0; ch_z = 0; f_prev = -1; dlq.delete();
                if (m_alarm == 1) m_clr = 1;
                m_alarm = 0;
            end else begin
                if (md == 0 && ch_stb) begin
                    ch_n++;
                    if (ch_bit2 == 1'b0) ch_z++;
                    if (ch_n == 256) begin
                        if (ch_z >= 254) want_on = 1; else want_off = 1;
                        ch_n = 0; ch_z = 0;
                    end
                end
                if (md == 1 && fb_stb) begin
                    if (f_prev == int'(fb_val)) begin
                        if (fb_val) want_on = 1; else want_off = 1;
                    end
                    f_prev = int'(fb_val);
                end
                if (md == 2 && dl_stb) begin
                    dlq.push_back(dl_byte);
                    if (dlq.size() == 32) begin
                        int hits;
                        hits = 0;
                        for (int i = 0; i < 16; i++)
                            if (dlq[2*i] == 8'h00 && dlq[2*i+1] == 8'hFF) hits++;
                        if (hits == 16) want_on = 1;
                        if (hits <= 14) want_off = 1;
                        dlq.delete();
                    end
                end
                if (want_on && m_alarm == 0) begin m_alarm = 1; m_set = 1; end
                else if (want_off && m_alarm == 1) begin m_alarm = 0; m_clr = 1; end
            end
            m_mode = md;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            n_cmp++;
            if (int'(yel_alarm) != m_alarm || int'(yel_set) != m_set || int'(yel_clr) != m_clr) begin
                n_bad++;
                $display("FAIL %s: alarm/set/clr actual %0d%0d%0d expected %0d%0d%0d",
                         cur_req, yel_alarm, yel_set, yel_clr, m_alarm, m_set, m_clr);
            end
        end
    end

    task automatic chk(input logic exp, input string req);
        n_cmp++;
        if (yel_alarm !== exp) begin
            n_bad++;
            $display("FAIL %s: yel_alarm actual %0b expected %0b", req, yel_alarm, exp);
        end
    endtask

    task automatic ch_run(input int total, input int zeros);
        for (int i = 0; i < total; i++) begin
            @(negedge clk);
            ch_stb = 1'b1;
            ch_bit2 = (i < total - zeros);
        end
        @(negedge clk);
        ch_stb = 1'b0;
    endtask

    task automatic fb(input logic v);
        @(negedge clk);
        fb_stb = 1'b1; fb_val = v;
        @(negedge clk);
        fb_stb = 1'b0;
    endtask

    task automatic dl_send(input logic [7:0] b);
        @(negedge clk);
        dl_stb = 1'b1; dl_byte = b;
        @(negedge clk);
        dl_stb = 1'b0;
    endtask

    task automatic pats(input int good);
        for (int i = 0; i < 16; i++) begin
            dl_send(8'h00);
            dl_send(i < good ? 8'hFF : 8'h7F);
        end
    endtask

    task automatic setmode(input logic e, input logic f);
        @(negedge clk);
        esf_sel = e; fbit_sel = f;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R1";
        chk(1'b0, "R1");

        cur_req = "R2"; ch_run(256, 256); chk(1'b1, "R2");
        ch_run(256, 254);                 chk(1'b1, "R2");
        cur_req = "R3"; ch_run(256, 253); chk(1'b0, "R3");
        ch_run(256, 0);                   chk(1'b0, "R3");
        cur_req = "R2"; ch_run(256, 255); chk(1'b1, "R2");

        cur_req = "R8";
        fb(1'b0); fb(1'b0); pats(3);      chk(1'b1, "R8");
        ch_run(256, 200);                 chk(1'b0, "R8");
        fb(1'b1); fb(1'b1); pats(16);     chk(1'b0, "R8");

        cur_req = "R9";
        ch_run(256, 256);                 chk(1'b1, "R9");
        setmode(1'b0, 1'b1);              chk(1'b0, "R9");

        cur_req = "R4";
        fb(1'b1); fb(1'b0); fb(1'b1); fb(1'b0); chk(1'b0, "R4");
        fb(1'b1); fb(1'b1);               chk(1'b1, "R4");
        cur_req = "R5";
        fb(1'b0); fb(1'b1); fb(1'b0);     chk(1'b1, "R5");
        fb(1'b0);                         chk(1'b0, "R5");

        cur_req = "R9";
        setmode(1'b0, 1'b0);
        ch_run(100, 100);
        setmode(1'b0, 1'b1);
        setmode(1'b0, 1'b0);
        ch_run(156, 156);                 chk(1'b0, "R9");
        ch_run(100, 100);                 chk(1'b1, "R9");

        setmode(1'b1, 1'b0);              chk(1'b0, "R9");
        cur_req = "R6"; pats(16);         chk(1'b1, "R6");
        cur_req = "R7"; pats(15);         chk(1'b1, "R7");
        pats(14);                         chk(1'b0, "R7");
        cur_req = "R6"; pats(15);         chk(1'b0, "R6");
        pats(16);                         chk(1'b1, "R6");
        cur_req = "R8"; setmode(1'b1, 1'b1); chk(1'b1, "R8");
        cur_req = "R10"; setmode(1'b0, 1'b0); chk(1'b0, "R10");
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule